// File: doc/BRIEF.md
# Host Command Exception Handshake Controller

This block sits between an external host bus and the exception logic of a DSP core. The host writes an 8-bit command register that holds a command-request flag and a small vector field. The DSP side gets a status word with three flags: receive full, transmit empty and command pending. The DSP also has its own 8-bit control register, and three of its bits enable the three exception sources. The host cannot reach this register.

From these inputs the block chooses one enabled pending source and presents it to the core as a single exception request with a starting address. The request stays in place until the core pulses acknowledge. When the core acknowledges a command exception, the block clears the command flag. The host polls that flag to learn that its command has started. The host may also clear the flag to withdraw a request that has not yet been acknowledged. A host request line tells the host when receive-full or transmit-empty is set together with its request enable.

Top module: `hostcmd_exc_ctrl`

## Requirements
- R1: After reset, the command flag, the vector, the control register and `exc_req` are all 0.
- R2: A host write loads the command flag from bit 7 and the vector from bits 4:0 in the same cycle. Reading the command register returns {flag, 2'b00, vector}, so bits 6:5 always read 0.
- R3: `dsp_stat` bit 2 (command pending) is equal to the command flag at all times. Bit 0 carries `rx_full` and bit 1 carries `tx_empty`.
- R4: A set command flag with control bit 2 set raises `exc_req` two clock edges after the host write, with `exc_addr` equal to twice the vector (0x0000 to 0x003E). With control bit 2 clear, no command exception is requested.
- R5: An acknowledge of a command exception clears the command flag at that same clock edge.
- R6: If the host clears the flag before the core acknowledges, `exc_req` drops in the cycle after the write and the command exception is not presented again.
- R7: An acknowledge and a host write in the same cycle: the acknowledge wins and the flag ends at 0, even if the write sets it. The vector still takes the written value.
- R8: Receive full, enabled by control bit 0, requests address 0x0028. Transmit empty, enabled by control bit 1, requests address 0x002A. A source whose enable bit is clear never raises a request.
- R9: When several enabled sources are pending at the same time, the command source wins first, then receive full, then transmit empty.
- R10: A presented request and its address stay unchanged until acknowledge, even if a higher-priority source becomes pending meanwhile.
- R11: The control register is 8 bits that the DSP can read and write. It reads back on a 16-bit bus whose upper byte is 0.
- R12: `host_req` = (`rx_full` AND `rx_req_en`) OR (`tx_empty` AND `tx_req_en`), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command register |
| host_wdata | input | 8 | Host write data: bit 7 = flag, bits 4:0 = vector |
| host_rdata | output | 8 | Command register read-back |
| dsp_ctl_we | input | 1 | DSP write strobe for the control register |
| dsp_ctl_wdata | input | 8 | Control write data: bit 0 rx enable, bit 1 tx enable, bit 2 command enable |
| dsp_ctl_rdata | output | 16 | Control register on the internal bus, upper byte 0 |
| rx_full | input | 1 | Receive data full status |
| tx_empty | input | 1 | Transmit data empty status |
| rx_req_en | input | 1 | Host-side enable of the request on receive full |
| tx_req_en | input | 1 | Host-side enable of the request on transmit empty |
| dsp_stat | output | 3 | {command pending, tx_empty, rx_full} |
| exc_req | output | 1 | Exception request to the core |
| exc_addr | output | 16 | Starting address of the presented exception |
| exc_ack | input | 1 | Core acknowledge, one-cycle pulse |
| host_req | output | 1 | Host request line |

## Verification
Register writes show up at the edge that takes the strobe. The bench drives the strobe on a falling edge and reads the result one falling edge later. An exception request appears one edge after its source becomes eligible, so a command write takes two edges to reach `exc_req`. The bench waits one extra falling edge after each write and after each change of enables before it samples. After an acknowledge, the command flag clears and the request drops at that same edge, and the next source is taken at the following edge. Each check samples in the cycle that matches these counts. `host_req` and the withdrawal after a cancel are combinational on registered state, so the bench checks them a short delay after the inputs change.

// File: rtl/hcx_pkg.sv
package hcx_pkg;

    localparam int HOST_W   = 8;
    localparam int FLAG_BIT = 7;
    localparam int NSRC     = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CMD  = 2'd1,
        SRC_RX   = 2'd2,
        SRC_TX   = 2'd3
    } src_e;

    // DSP-side control byte; enable bits sit at the low end
    typedef struct packed {
        logic [4:0] spare;
        logic       cmd_ie;
        logic       tx_ie;
        logic       rx_ie;
    } ctl_t;

    typedef struct packed {
        logic  vld;
        src_e  src;
        logic [15:0] addr;
    } exc_t;

    localparam logic [15:0] RX_START = 16'h0028;
    localparam logic [15:0] TX_START = 16'h002A;

    // Command start address: vector times two, zero extended
    function automatic logic [15:0] cmd_start(input logic [4:0] vec);
        logic [15:0] a;
        a = '0;
        a[5:1] = vec;
        return a;
    endfunction

endpackage

// File: rtl/hcx_cmd_reg.sv
module hcx_cmd_reg
    import hcx_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HOST_W-1:0] wdata,
    input  logic              take,
    output logic              flag,
    output logic [VEC_W-1:0]  vec,
    output logic [HOST_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            vec  <= '0;
        end else begin
            if (wr_en) begin
                flag <= wdata[FLAG_BIT];
                vec  <= wdata[VEC_W-1:0];
            end
            // acceptance by the core overrides any host write of the flag
            if (take) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata               = '0;
        rdata[FLAG_BIT]     = flag;
        rdata[VEC_W-1:0]    = vec;
    end

endmodule

// File: rtl/hcx_ctl_reg.sv
module hcx_ctl_reg
    import hcx_pkg::*;
#(
    parameter int CTL_W = 8,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic [BUS_W-1:0] rdata
);

    logic [CTL_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    assign ctl   = ctl_t'(q);
    assign rdata = {{(BUS_W-CTL_W){1'b0}}, q};

endmodule

// File: rtl/hcx_exc_arb.sv
module hcx_exc_arb
    import hcx_pkg::*;
#(
    parameter int VEC_W  = 5,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              cmd_flag,
    input  logic [VEC_W-1:0]  vec,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output src_e              cur_src,
    output logic              take_cmd
);

    logic [NSRC-1:0] pend;
    exc_t            cand [NSRC];
    exc_t            pick;
    exc_t            cur;
    logic            cancelled;

    // index 0 is the highest priority
    assign pend[0] = cmd_flag && ctl.cmd_ie;
    assign pend[1] = rx_full  && ctl.rx_ie;
    assign pend[2] = tx_empty && ctl.tx_ie;

    assign cand[0] = '{vld: pend[0], src: SRC_CMD, addr: cmd_start(vec)};
    assign cand[1] = '{vld: pend[1], src: SRC_RX,  addr: RX_START};
    assign cand[2] = '{vld: pend[2], src: SRC_TX,  addr: TX_START};

    always_comb begin
        pick = '0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (cand[i].vld) begin
                pick = cand[i];
            end
        end
    end

    assign cancelled = (cur.src == SRC_CMD) && !cmd_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (cur.vld) begin
            if (ack || cancelled) begin
                cur <= '0;
            end
        end else if (pick.vld) begin
            cur <= pick;
        end
    end

    assign req      = cur.vld && !cancelled;
    assign addr     = cur.addr[ADDR_W-1:0];
    assign cur_src  = cur.src;
    assign take_cmd = req && ack && (cur.src == SRC_CMD);

endmodule

// File: rtl/hostcmd_exc_ctrl.sv
module hostcmd_exc_ctrl
    import hcx_pkg::*;
#(
    parameter int VEC_W  = 5,
    parameter int CTL_W  = 8,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              dsp_ctl_we,
    input  logic [CTL_W-1:0]  dsp_ctl_wdata,
    output logic [BUS_W-1:0]  dsp_ctl_rdata,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              rx_req_en,
    input  logic              tx_req_en,
    output logic [2:0]        dsp_stat,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_addr,
    input  logic              exc_ack,
    output logic              host_req
);

    logic             cmd_flag;
    logic [VEC_W-1:0] vec;
    logic             take_cmd;
    ctl_t             ctl;
    src_e             arb_src;

    hcx_cmd_reg #(.VEC_W(VEC_W)) u_cmd (
        .clk   (clk),
        .rst   (rst),
        .wr_en (host_we),
        .wdata (host_wdata),
        .take  (take_cmd),
        .flag  (cmd_flag),
        .vec   (vec),
        .rdata (host_rdata)
    );

    hcx_ctl_reg #(.CTL_W(CTL_W), .BUS_W(BUS_W)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dsp_ctl_we),
        .wdata (dsp_ctl_wdata),
        .ctl   (ctl),
        .rdata (dsp_ctl_rdata)
    );

    hcx_exc_arb #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cmd_flag (cmd_flag),
        .vec      (vec),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .ack      (exc_ack),
        .req      (exc_req),
        .addr     (exc_addr),
        .cur_src  (arb_src),
        .take_cmd (take_cmd)
    );

    assign dsp_stat = {cmd_flag, tx_empty, rx_full};
    assign host_req = (rx_full && rx_req_en) || (tx_empty && tx_req_en);

endmodule

// File: rtl/hcx_chk.sv
module hcx_chk
    import hcx_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        host_rdata,
    input logic [BUS_W-1:0]  dsp_ctl_rdata,
    input logic [2:0]        dsp_stat,
    input logic              exc_req,
    input logic [ADDR_W-1:0] exc_addr,
    input logic              exc_ack,
    input src_e              src
);

    p_pend_r3: assert property (@(posedge clk) disable iff (rst)
        dsp_stat[2] == host_rdata[7]);

    p_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
        host_rdata[6:5] == 2'b00);

    p_upper_r11: assert property (@(posedge clk) disable iff (rst)
        dsp_ctl_rdata[BUS_W-1:8] == '0);

    p_take_r5: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_ack && src == SRC_CMD) |=> !host_rdata[7]);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !exc_ack) |=> $stable(exc_addr));

    p_cmdlive_r6: assert property (@(posedge clk) disable iff (rst)
        (exc_req && src == SRC_CMD) |-> host_rdata[7]);

    p_rxaddr_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && src == SRC_RX) |-> exc_addr == ADDR_W'(16'h0028));

    p_txaddr_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && src == SRC_TX) |-> exc_addr == ADDR_W'(16'h002A));

endmodule

bind hostcmd_exc_ctrl hcx_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_rdata    (host_rdata),
    .dsp_ctl_rdata (dsp_ctl_rdata),
    .dsp_stat      (dsp_stat),
    .exc_req       (exc_req),
    .exc_addr      (exc_addr),
    .exc_ack       (exc_ack),
    .src           (arb_src)
);

// File: tb/hostcmd_exc_ctrl_tb.sv
`timescale 1ns/1ps
module hostcmd_exc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dsp_ctl_we = 1'b0;
    logic [7:0]  dsp_ctl_wdata = '0;
    logic [15:0] dsp_ctl_rdata;
    logic        rx_full = 1'b0, tx_empty = 1'b0;
    logic        rx_req_en = 1'b0, tx_req_en = 1'b0;
    logic [2:0]  dsp_stat;
    logic        exc_req;
    logic [15:0] exc_addr;
    logic        exc_ack;
    logic        host_req;
    logic        man_ack = 1'b0;
    logic        mon_ack = 1'b0;
    logic        auto_ack = 1'b0;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_q [$];

    always #2 clk = ~clk;

    assign exc_ack = man_ack | mon_ack;

    hostcmd_exc_ctrl u_dut (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_ctl_we(dsp_ctl_we), .dsp_ctl_wdata(dsp_ctl_wdata), .dsp_ctl_rdata(dsp_ctl_rdata),
        .rx_full(rx_full), .tx_empty(tx_empty),
        .rx_req_en(rx_req_en), .tx_req_en(tx_req_en),
        .dsp_stat(dsp_stat), .exc_req(exc_req), .exc_addr(exc_addr),
        .exc_ack(exc_ack), .host_req(host_req)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, expv);
        end
    endtask

    task automatic host_wr(input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic dsp_wr(input logic [7:0] v);
        @(negedge clk);
        dsp_ctl_we = 1'b1; dsp_ctl_wdata = v;
        @(negedge clk);
        dsp_ctl_we = 1'b0;
    endtask

    task automatic pulse_ack;
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
    endtask

    // monitor: pops the expected start address and acknowledges
    always @(negedge clk) begin
        if (rst) begin
            mon_ack <= 1'b0;
        end else if (mon_ack) begin
            mon_ack <= 1'b0;
        end else if (auto_ack && exc_req) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected exception", {16'h0, exc_addr}, 32'hFFFF_FFFF);
            end else begin
                chk("R4/R8 scoreboard address", {16'h0, exc_addr}, {16'h0, exp_q.pop_front()});
            end
            mon_ack <= 1'b1;
        end
    end

    task automatic auto_cmd(input logic [4:0] v);
        logic cleared;
        exp_q.push_back({10'h0, v, 1'b0});
        host_wr({3'b100, v});
        cleared = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!cleared && host_rdata[7] == 1'b0) cleared = 1'b1;
            if (!cleared) @(negedge clk);
        end
        chk("R5 flag cleared on acceptance", {31'h0, cleared}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 host reg after reset", {24'h0, host_rdata}, 32'h0);
        chk("R1 ctl after reset", {16'h0, dsp_ctl_rdata}, 32'h0);
        chk("R1 no request after reset", {31'h0, exc_req}, 32'h0);

        // R11
        dsp_wr(8'hA5);
        chk("R11 ctl readback", {16'h0, dsp_ctl_rdata}, 32'h0000_00A5);
        dsp_wr(8'h00);

        // R2, R3, R4 gating
        host_wr(8'hFF);
        chk("R2 flag+vector, bits 6:5 zero", {24'h0, host_rdata}, 32'h9F);
        chk("R3 pending flag", {29'h0, dsp_stat}, 32'h4);
        repeat (3) @(negedge clk);
        chk("R4 disabled command not requested", {31'h0, exc_req}, 32'h0);
        host_wr(8'h00);
        chk("R3 pending cleared", {31'h0, dsp_stat[2]}, 32'h0);

        // R12
        rx_full = 1'b1; #1;
        chk("R12 rx without enable", {31'h0, host_req}, 32'h0);
        rx_req_en = 1'b1; #1;
        chk("R12 rx with enable", {31'h0, host_req}, 32'h1);
        rx_full = 1'b0; tx_empty = 1'b1; #1;
        chk("R12 tx without enable", {31'h0, host_req}, 32'h0);
        tx_req_en = 1'b1; #1;
        chk("R12 tx with enable", {31'h0, host_req}, 32'h1);
        chk("R3 tx_empty in status", {29'h0, dsp_stat}, 32'h2);
        tx_empty = 1'b0; rx_req_en = 1'b0; tx_req_en = 1'b0;

        // R8 gating with only command enabled
        dsp_wr(8'h04);
        rx_full = 1'b1; tx_empty = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 disabled rx/tx not requested", {31'h0, exc_req}, 32'h0);
        rx_full = 1'b0; tx_empty = 1'b0;

        // R9 priority and R10 hold
        dsp_wr(8'h00);
        host_wr(8'h83);
        rx_full = 1'b1; tx_empty = 1'b1;
        dsp_wr(8'h07);
        @(negedge clk);
        chk("R9 command first", {15'h0, exc_req, exc_addr}, 32'h1_0006);
        repeat (3) @(negedge clk);
        chk("R10 held without ack", {15'h0, exc_req, exc_addr}, 32'h1_0006);
        pulse_ack();
        chk("R5 flag cleared by ack", {31'h0, host_rdata[7]}, 32'h0);
        @(negedge clk);
        chk("R9 receive second", {15'h0, exc_req, exc_addr}, 32'h1_0028);
        pulse_ack();
        rx_full = 1'b0;
        @(negedge clk);
        chk("R9 transmit last", {15'h0, exc_req, exc_addr}, 32'h1_002A);
        host_wr(8'h84);
        repeat (3) @(negedge clk);
        chk("R10 no preemption by command", {15'h0, exc_req, exc_addr}, 32'h1_002A);
        pulse_ack();
        tx_empty = 1'b0;
        @(negedge clk);
        chk("R4 command address 2*4", {15'h0, exc_req, exc_addr}, 32'h1_0008);
        pulse_ack();

        // R6 cancel before acknowledge
        host_wr(8'h85);
        @(negedge clk);
        chk("R4 command address 2*5", {15'h0, exc_req, exc_addr}, 32'h1_000A);
        host_wr(8'h05);
        chk("R6 request withdrawn", {31'h0, exc_req}, 32'h0);
        chk("R6 readback after cancel", {24'h0, host_rdata}, 32'h05);
        repeat (3) @(negedge clk);
        chk("R6 stays withdrawn", {31'h0, exc_req}, 32'h0);

        // R7 cancel racing acknowledge
        host_wr(8'h86);
        @(negedge clk);
        chk("R4 command address 2*6", {15'h0, exc_req, exc_addr}, 32'h1_000C);
        host_we = 1'b1; host_wdata = 8'h06; man_ack = 1'b1;
        @(negedge clk);
        host_we = 1'b0; man_ack = 1'b0;
        chk("R7 cancel+ack flag 0", {24'h0, host_rdata}, 32'h06);
        chk("R7 request gone", {31'h0, exc_req}, 32'h0);
        host_wr(8'h86);
        @(negedge clk);
        host_we = 1'b1; host_wdata = 8'h89; man_ack = 1'b1;
        @(negedge clk);
        host_we = 1'b0; man_ack = 1'b0;
        chk("R7 ack beats set, vector loads", {24'h0, host_rdata}, 32'h09);

        // scoreboard-driven runs
        @(negedge clk);
        auto_ack = 1'b1;
        auto_cmd(5'd0);
        auto_cmd(5'd31);
        auto_cmd(5'd5);
        exp_q.push_back(16'h0028);
        rx_full = 1'b1;
        @(posedge exc_ack);
        @(negedge clk);
        rx_full = 1'b0;
        exp_q.push_back(16'h002A);
        tx_empty = 1'b1;
        @(posedge exc_ack);
        @(negedge clk);
        tx_empty = 1'b0;
        repeat (3) @(negedge clk);
        auto_ack = 1'b0;
        chk("R8 all expected exceptions seen", exp_q.size(), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule